// File: doc/BRIEF.md
# Trigger-gated frame capture buffer

This block sits on one continuously streaming chain of zero-suppressed sensor data. Each valid beat carries the 20-bit address of one hit pixel. The sensor scans its pixel array in ascending address order, frame after frame. No signal marks where one frame ends. A frame boundary is found when an incoming address is not greater than the address of the previous valid beat, which shows that the scan has wrapped.

A trigger pulse reserves one of two event slots. The reserved slot captures the next complete frame, and the capture begins at the next boundary. The frame that is in progress when the trigger arrives is never stored. The input has no ready signal and is never stalled. Because there are two slots, a new frame can be captured while the previous event is still being drained. Capture adds no dead time for as long as a slot is free.

A downstream event builder reads completed slots through a valid/ready port. It sees the word count, a truncation flag and a last-word marker. Events leave in the order their triggers were accepted.

Top module: `fcap_trig_frame_buf`

## Requirements
- R1: While reset is held and in the first cycle after reset, `rd_valid`, `rd_last`, `busy` and `ovf` are all 0.
- R2: A boundary is a beat with `in_valid`=1 whose `in_addr` is less than or equal to the address of the most recent earlier beat with `in_valid`=1. The first valid beat after reset is never a boundary. Cycles with `in_valid`=0 neither count as beats nor update the remembered address.
- R3: An accepted trigger takes effect from the following cycle. Capture starts at the first boundary beat after that, and that boundary beat is stored as word 0. Words of the frame in progress when the trigger arrives are never stored.
- R4: A capturing slot completes at the next boundary beat, and that beat is not stored in it. If the other slot is waiting for its frame, the same boundary beat becomes that slot's word 0, so two triggers capture two consecutive frames.
- R5: The two slots are reserved alternately, in the order triggers arrive. A trigger is accepted while the other slot is still being read out.
- R6: `busy` is 1 when the slot next in line for reservation is not free. A trigger that arrives while `busy` is 1 (as registered at the start of that cycle) is dropped. The drop sets the sticky `ovf` flag, which stays 1 until reset, and leaves the stored events unchanged.
- R7: A slot stores at most DEPTH (512) words of a frame. Extra words are discarded, and the event is presented with `rd_count`=DEPTH and `rd_trunc`=1. It still completes at the frame's end boundary.
- R8: While the oldest completed event is presented, `rd_valid`=1 and `rd_count` gives its word count. `rd_data` shows words in arrival order, starting with word 0. Each cycle with `rd_valid` and `rd_ready` both 1 advances to the next word. With `rd_ready`=0 the outputs hold.
- R9: `rd_last` is 1 on the final word of an event. Accepting that word frees the slot, and the next completed event (if any) is presented from the next cycle, in trigger order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture and readout clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input beat carries a hit address |
| in_addr | input | 20 | Hit pixel address |
| trig | input | 1 | Trigger pulse, one cycle per request |
| rd_ready | input | 1 | Event builder accepts the presented word |
| rd_valid | output | 1 | A completed event word is presented |
| rd_data | output | 20 | Presented address word |
| rd_count | output | 10 | Word count of the presented event |
| rd_trunc | output | 1 | Presented event was cut at DEPTH words |
| rd_last | output | 1 | Presented word is the final word of its event |
| busy | output | 1 | Next slot in line is not free; a trigger now would be dropped |
| ovf | output | 1 | Sticky: at least one trigger was dropped |

## Verification
The bench goes after the following corner cases:
- A trigger that lands in the middle of a frame. A design that stored at once would leak the partial frame into the event.
- A next frame that starts with an address equal to the previous one. A strict less-than compare would merge the two frames.
- Two triggers before one boundary. A design without the handoff at the boundary would lose the second frame or give both slots the same one.
- Idle cycles that carry a high address. These would create false boundaries if such cycles were taken as beats.
- A trigger that lands while both slots are held, which must set the overflow flag without touching the stored events.
- A frame longer than the slot. This must truncate at the limit and still end at the true boundary.
- Readout with a toggling ready, which exposes any word skipped or repeated around the release of a slot.

// File: rtl/fcap_pkg.sv
package fcap_pkg;
  // life cycle of one event slot
  typedef enum logic [1:0] {
    SLOT_FREE,
    SLOT_ARMED,
    SLOT_FILL,
    SLOT_DONE
  } slot_st_e;
endpackage

// File: rtl/fcap_edge_det.sv
module fcap_edge_det #(
  parameter int AW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          beat_vld,
  input  logic [AW-1:0] beat_addr,
  output logic          wrap_o
);
  logic          seen_q, seen_d;
  logic [AW-1:0] last_q, last_d;

  // scan restart: address did not climb past the previous one
  assign wrap_o = beat_vld && seen_q && (beat_addr <= last_q);

  always_comb begin
    seen_d = seen_q;
    last_d = last_q;
    if (beat_vld) begin
      seen_d = 1'b1;
      last_d = beat_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      last_q <= '0;
    end else begin
      seen_q <= seen_d;
      last_q <= last_d;
    end
  end
endmodule

// File: rtl/fcap_slot_mem.sv
module fcap_slot_mem #(
  parameter int AW    = 20,
  parameter int DEPTH = 512,
  localparam int IW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          push_i,
  input  logic [AW-1:0] din_i,
  input  logic [IW-1:0] rd_idx_i,
  output logic [AW-1:0] dout_o,
  output logic [CW-1:0] count_o,
  output logic          trunc_o
);
  logic [AW-1:0] mem [DEPTH];
  logic [CW-1:0] cnt_q, cnt_d;
  logic          tr_q, tr_d;
  logic          we;
  logic [IW-1:0] wa;
  logic          room;

  always_comb begin
    room  = cnt_q < CW'(DEPTH);
    we    = 1'b0;
    wa    = cnt_q[IW-1:0];
    cnt_d = cnt_q;
    tr_d  = tr_q;
    if (start_i) begin
      we    = 1'b1;
      wa    = '0;
      cnt_d = CW'(1);
      tr_d  = 1'b0;
    end else if (push_i) begin
      if (room) begin
        we    = 1'b1;
        cnt_d = cnt_q + CW'(1);
      end else begin
        tr_d = 1'b1;
      end
    end
  end

  // storage array carries no reset; occupancy is tracked by cnt_q
  always_ff @(posedge clk) begin
    if (we) mem[wa] <= din_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      tr_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      tr_q  <= tr_d;
    end
  end

  assign dout_o  = mem[rd_idx_i];
  assign count_o = cnt_q;
  assign trunc_o = tr_q;
endmodule

// File: rtl/fcap_trig_frame_buf.sv
module fcap_trig_frame_buf
  import fcap_pkg::*;
#(
  parameter int AW    = 20,
  parameter int DEPTH = 512,
  localparam int IW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [AW-1:0] in_addr,
  input  logic          trig,
  input  logic          rd_ready,
  output logic          rd_valid,
  output logic [AW-1:0] rd_data,
  output logic [CW-1:0] rd_count,
  output logic          rd_trunc,
  output logic          rd_last,
  output logic          busy,
  output logic          ovf
);
  localparam int NSLOT = 2;

  slot_st_e      st_q [NSLOT];
  slot_st_e      st_d [NSLOT];
  logic          alloc_q, alloc_d;   // next slot to reserve
  logic          cap_q, cap_d;       // oldest slot not yet completed
  logic          rd_q, rd_d;         // oldest slot not yet drained
  logic [IW-1:0] idx_q, idx_d;
  logic          ovf_q, ovf_d;
  logic          oth;
  logic          wrap;

  logic [NSLOT-1:0] start_v, push_v;
  logic [AW-1:0]    dout  [NSLOT];
  logic [CW-1:0]    cnt   [NSLOT];
  logic [NSLOT-1:0] trv;

  fcap_edge_det #(.AW(AW)) u_edge (
    .clk       (clk),
    .rst_n     (rst_n),
    .beat_vld  (in_valid),
    .beat_addr (in_addr),
    .wrap_o    (wrap)
  );

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    fcap_slot_mem #(.AW(AW), .DEPTH(DEPTH)) u_mem (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (start_v[g]),
      .push_i   (push_v[g]),
      .din_i    (in_addr),
      .rd_idx_i (idx_q),
      .dout_o   (dout[g]),
      .count_o  (cnt[g]),
      .trunc_o  (trv[g])
    );
  end

  assign oth      = ~cap_q;
  assign rd_valid = (st_q[rd_q] == SLOT_DONE);
  assign rd_data  = dout[rd_q];
  assign rd_count = cnt[rd_q];
  assign rd_trunc = trv[rd_q];
  assign rd_last  = rd_valid && ((CW'(idx_q) + CW'(1)) == cnt[rd_q]);
  assign busy     = (st_q[alloc_q] != SLOT_FREE);
  assign ovf      = ovf_q;

  always_comb begin
    st_d    = st_q;
    alloc_d = alloc_q;
    cap_d   = cap_q;
    rd_d    = rd_q;
    idx_d   = idx_q;
    ovf_d   = ovf_q;
    start_v = '0;
    push_v  = '0;

    // capture side: only the oldest pending slot sees the stream
    if (in_valid) begin
      if (st_q[cap_q] == SLOT_FILL) begin
        if (wrap) begin
          st_d[cap_q] = SLOT_DONE;
          cap_d       = oth;
          if (st_q[oth] == SLOT_ARMED) begin
            st_d[oth]    = SLOT_FILL;
            start_v[oth] = 1'b1;
          end
        end else begin
          push_v[cap_q] = 1'b1;
        end
      end else if ((st_q[cap_q] == SLOT_ARMED) && wrap) begin
        st_d[cap_q]    = SLOT_FILL;
        start_v[cap_q] = 1'b1;
      end
    end

    // trigger side: reserve in order, drop when the next slot is held
    if (trig) begin
      if (st_q[alloc_q] == SLOT_FREE) begin
        st_d[alloc_q] = SLOT_ARMED;
        alloc_d       = ~alloc_q;
      end else begin
        ovf_d = 1'b1;
      end
    end

    // readout side
    if (rd_valid && rd_ready) begin
      if (rd_last) begin
        st_d[rd_q] = SLOT_FREE;
        rd_d       = ~rd_q;
        idx_d      = '0;
      end else begin
        idx_d = idx_q + IW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NSLOT; i++) st_q[i] <= SLOT_FREE;
      alloc_q <= 1'b0;
      cap_q   <= 1'b0;
      rd_q    <= 1'b0;
      idx_q   <= '0;
      ovf_q   <= 1'b0;
    end else begin
      for (int i = 0; i < NSLOT; i++) st_q[i] <= st_d[i];
      alloc_q <= alloc_d;
      cap_q   <= cap_d;
      rd_q    <= rd_d;
      idx_q   <= idx_d;
      ovf_q   <= ovf_d;
    end
  end
endmodule

// File: rtl/fcap_chk.sv
module fcap_chk #(
  parameter int AW    = 20,
  parameter int DEPTH = 512,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          trig,
  input logic          rd_ready,
  input logic          rd_valid,
  input logic [AW-1:0] rd_data,
  input logic [CW-1:0] rd_count,
  input logic          rd_trunc,
  input logic          busy,
  input logic          ovf
);
  // R6: overflow flag never falls outside reset
  a_r6_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf);

  // R6: a trigger meeting a held slot is recorded
  a_r6_drop_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && busy) |=> ovf);

  // R8: presented word holds while the consumer stalls
  a_r8_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data) && $stable(rd_count)));

  // R8: a presented event has between one and DEPTH words
  a_r8_count_range: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (rd_count != '0 && rd_count <= CW'(DEPTH)));

  // R7: a truncated event is always full
  a_r7_trunc_full: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_trunc) |-> (rd_count == CW'(DEPTH)));
endmodule

bind fcap_trig_frame_buf fcap_chk #(.AW(AW), .DEPTH(DEPTH)) u_fcap_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .trig     (trig),
  .rd_ready (rd_ready),
  .rd_valid (rd_valid),
  .rd_data  (rd_data),
  .rd_count (rd_count),
  .rd_trunc (rd_trunc),
  .busy     (busy),
  .ovf      (ovf)
);

// File: tb/test_fcap_trig_frame_buf.sv
module test_fcap_trig_frame_buf;
  localparam int CLK_PERIOD = 10;
  localparam int AW    = 20;
  localparam int DEPTH = 512;
  localparam int CW    = $clog2(DEPTH + 1);
  localparam int WATCHDOG = 150000;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid, trig, rd_ready;
  logic [AW-1:0] in_addr;
  logic          rd_valid, rd_trunc, rd_last, busy, ovf;
  logic [AW-1:0] rd_data;
  logic [CW-1:0] rd_count;

  int    n_cmp = 0, n_bad = 0, cyc = 0, ready_mode = 0;
  bit    started = 0, finished = 0;
  string tag = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  fcap_trig_frame_buf #(.AW(AW), .DEPTH(DEPTH)) i_fcap_trig_frame_buf (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_addr(in_addr),
    .trig(trig), .rd_ready(rd_ready), .rd_valid(rd_valid), .rd_data(rd_data),
    .rd_count(rd_count), .rd_trunc(rd_trunc), .rd_last(rd_last),
    .busy(busy), .ovf(ovf));

  // ---------------- behavioural reference ----------------
  // slot codes: 0 free, 1 waiting for frame, 2 capturing, 3 complete
  int            mst [2];
  logic [AW-1:0] mq0 [$];
  logic [AW-1:0] mq1 [$];
  bit            mtr [2];
  int            malloc, mcap, mrd, midx;
  bit            movf, mseen;
  logic [AW-1:0] mprev;

  function automatic int msize(int b);
    return (b == 0) ? mq0.size() : mq1.size();
  endfunction

  function automatic void mstart(int b, logic [AW-1:0] d);
    if (b == 0) begin mq0.delete(); mq0.push_back(d); end
    else begin mq1.delete(); mq1.push_back(d); end
    mtr[b] = 0;
  endfunction

  function automatic void mpush(int b, logic [AW-1:0] d);
    if (msize(b) >= DEPTH) mtr[b] = 1;
    else if (b == 0) mq0.push_back(d);
    else mq1.push_back(d);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mst[0] = 0; mst[1] = 0; mtr[0] = 0; mtr[1] = 0;
      mq0.delete(); mq1.delete();
      malloc = 0; mcap = 0; mrd = 0; midx = 0;
      movf = 0; mseen = 0; mprev = '0;
    end else begin : step
      int s [2];
      int c, o, sz;
      bit brk;
      s[0] = mst[0]; s[1] = mst[1];
      c = mcap; o = 1 - mcap;
      brk = in_valid && mseen && (in_addr <= mprev);
      if (in_valid) begin
        if (s[c] == 2) begin
          if (brk) begin
            mst[c] = 3; mcap = o;
            if (s[o] == 1) begin mst[o] = 2; mstart(o, in_addr); end
          end else mpush(c, in_addr);
        end else if (s[c] == 1 && brk) begin
          mst[c] = 2; mstart(c, in_addr);
        end
        mseen = 1; mprev = in_addr;
      end
      if (trig) begin
        if (s[malloc] == 0) begin mst[malloc] = 1; malloc = 1 - malloc; end
        else movf = 1;
      end
      if (s[mrd] == 3 && rd_ready) begin
        sz = msize(mrd);
        if (midx == sz - 1) begin mst[mrd] = 0; mrd = 1 - mrd; midx = 0; end
        else midx++;
      end
    end
  end

  // ---------------- comparison, away from the active edge ----------------
  function automatic void chk(string f, longint act, longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h (cycle %0d)", tag, f, act, exp, cyc);
    end
  endfunction

  always @(negedge clk) begin
    if (started && !finished) begin : cmp
      bit ev;
      ev = (mst[mrd] == 3);
      chk("rd_valid", rd_valid, ev);
      chk("busy R6", busy, mst[malloc] != 0);
      chk("ovf R6", ovf, movf);
      chk("rd_last R9", rd_last, ev && (midx == msize(mrd) - 1));
      if (ev) begin
        chk("rd_count R8", rd_count, msize(mrd));
        chk("rd_trunc R7", rd_trunc, mtr[mrd]);
        chk("rd_data R8", rd_data, (mrd == 0) ? mq0[midx] : mq1[midx]);
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic beat(input bit v, input logic [AW-1:0] a, input bit t);
    @(negedge clk);
    cyc++;
    in_valid = v; in_addr = a; trig = t;
    case (ready_mode)
      1: rd_ready = 1'b1;
      2: rd_ready = cyc[0] ^ cyc[2];
      default: rd_ready = 1'b0;
    endcase
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) beat(1'b0, '0, 1'b0);
  endtask

  // ascending run of addresses; optional trigger on word trig_at;
  // gaps insert invalid cycles carrying a high address
  task automatic frame(input int n, input int start, input int stp,
                       input int trig_at, input bit gaps);
    for (int i = 0; i < n; i++) begin
      if (gaps && (i % 4) == 3) beat(1'b0, {AW{1'b1}}, 1'b0);
      beat(1'b1, AW'(start + i * stp), i == trig_at);
    end
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_addr = '0; trig = 1'b0; rd_ready = 1'b0;
    started = 1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: quiet outputs after reset
    tag = "R1"; idle(3);

    // R3: trigger mid-frame, next frame captured, partial one skipped
    tag = "R3"; ready_mode = 1;
    frame(40, 100, 3, 10, 1'b0);
    frame(30, 5, 7, -1, 1'b1);
    frame(20, 2, 1, -1, 1'b0);
    idle(5);

    // R2: equal address starts a frame; invalid high-address cycles ignored
    tag = "R2";
    frame(10, 10, 3, 2, 1'b0);
    frame(8, 37, 2, -1, 1'b1);
    frame(5, 1, 1, -1, 1'b1);
    idle(5);

    // R4: two triggers before one boundary, consecutive frames
    tag = "R4"; ready_mode = 0;
    frame(6, 50, 1, 2, 1'b0);
    frame(6, 56, 1, 1, 1'b0);
    frame(15, 0, 2, -1, 1'b0);
    frame(9, 1, 5, -1, 1'b0);
    frame(4, 0, 1, -1, 1'b0);

    // R6: both slots held, trigger dropped, contents intact
    tag = "R6";
    frame(5, 0, 1, 2, 1'b0);
    beat(1'b0, '0, 1'b1);
    idle(2);

    // R8: drain with stalling consumer
    tag = "R8"; ready_mode = 2;
    idle(40);

    // R5: triggers accepted while the other slot drains
    tag = "R5";
    frame(20, 3, 2, 4, 1'b1);
    frame(25, 1, 3, 5, 1'b0);
    frame(10, 0, 1, -1, 1'b0);
    frame(10, 0, 1, -1, 1'b0);
    idle(60);

    // R7: oversized frame truncated at DEPTH
    tag = "R7"; ready_mode = 0;
    frame(5, 0, 1, 1, 1'b0);
    frame(600, 0, 1, -1, 1'b0);
    frame(3, 0, 1, -1, 1'b0);
    ready_mode = 1;
    idle(700);

    // R9: last-word release and strict order with back-to-back events
    tag = "R9";
    frame(6, 0, 1, 0, 1'b0);
    frame(7, 0, 1, 3, 1'b0);
    frame(8, 0, 1, -1, 1'b0);
    frame(5, 0, 1, -1, 1'b0);
    idle(30);

    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < WATCHDOG; i++) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired in phase %s", tag);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule